// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between an internal clocked request bus and an external 16-bit asynchronous static RAM with an 18-bit word address and one active-low select per byte lane. It accepts one single-word read or write at a time and turns it into a registered strobe sequence on the RAM pins: address, active-low chip select, output enable, write enable and the per-lane byte selects. It also controls the block's own data drivers, which are split into an output value, a driver enable and a separate input path. Read data is captured into a register and returned with a one-cycle valid pulse. Every request is answered with a one-cycle acknowledge.

All timing is counted in clock cycles and set by parameters: the read access length, the write-enable pulse length and the idle turnaround time between a read releasing the bus and a write driving it. Lane 0 (bits 7:0) maps to byte select bit 0 and lane 1 (bits 15:8) maps to byte select bit 1. A request with an empty byte mask never reaches the RAM.

Top module: `sram_ctl`

## Requirements
- R1: After reset, chip select, output enable, write enable and both byte selects are high (inactive), the data driver enable is 0, and ack and rvalid are 0.
- R2: A read with a non-empty mask holds chip select and output enable low and write enable high for RD_CYC cycles. Byte select bit l is low exactly when be[l] is 1. The ack and rvalid outputs pulse together, RD_CYC+1 cycles after the request is presented to an idle controller.
- R3: Read data lane l (bits 8l+7:8l) equals the RAM byte on that lane when be[l] is 1, and is 0 when be[l] is 0.
- R4: A write with a non-empty mask first spends one cycle with chip select and the selected byte selects low and write enable high. It then holds write enable low for WP_CYC cycles, and only the lanes with be set are written. The ack pulses as write enable rises, WP_CYC+2 cycles after the request, and rvalid stays 0.
- R5: The RAM address equals the request address during the whole access and never changes while chip select is low.
- R6: The data driver enable is 1 only while write enable and chip select are both low. It falls on the same edge at which write enable rises, and the driven word is held valid for the whole pulse.
- R7: A write with a non-empty mask is not accepted until TA_CYC cycles after the edge that ends a read. Back-to-back after a read, its ack comes TA_CYC+WP_CYC+2 cycles after the request.
- R8: A request with be = 0 is acknowledged on the next edge without lowering chip select. A read of this kind returns rvalid with rdata = 0, and a write of this kind leaves memory unchanged.
- R9: Output enable and write enable are never low together, and chip select is never low with both byte selects high.
- R10: Requests issued back to back are served without idle cycles: a read is acked RD_CYC+1 cycles after the request, and a write after a write WP_CYC+2 cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request valid, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 16 | Write data |
| be | input | 2 | Active-high byte enables, bit 0 = bits 7:0 |
| ack | output | 1 | One-cycle request acknowledge |
| rvalid | output | 1 | Read data valid, pulses with ack on reads |
| rdata | output | 16 | Read data, unselected lanes 0 |
| sram_addr | output | 18 | RAM address |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_bsel_n | output | 2 | RAM byte selects, active low, bit 0 = lower lane |
| sram_dq_out | output | 16 | Value for the data pins when driving |
| sram_dq_oe | output | 1 | Data pin driver enable |
| sram_dq_in | input | 16 | Value seen on the data pins |

## Verification
The hardest case to reach is a write that arrives while the turnaround window after a read is still open. It shows up only when the write is issued within TA_CYC cycles of the read's end, so the random stream mixes zero-gap and short-gap sequences and the bench predicts each ack edge from the last read's end. A behavioural byte-lane memory model returns junk on a lane until the read has been stable for the access time. The model also commits a write only when the strobe overlap closes, so early capture, lane crossing and address movement inside a strobe all show up as wrong data. Directed empty-mask requests check that no strobe appears at all.

// File: rtl/sram_ctl_pkg.sv
// Shared types for the asynchronous static RAM controller.
// Assumes: one access in flight at a time.
package sram_ctl_pkg;

    // Sequencer phase: idle, read access, write setup, write-enable pulse.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WSETUP = 2'd2,
        ST_WPULSE = 2'd3
    } ctl_state_t;

endpackage

// File: rtl/sram_ctl_seq.sv
// Access sequencer: accepts requests, walks the read or write phases with
// cycle counters, holds the turnaround window after a read, issues ack.
// Assumes: req is held with stable fields until ack; RD_CYC, WP_CYC >= 1.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int AW     = 18,
    parameter int DW     = 16,
    parameter int RD_CYC = 2,
    parameter int WP_CYC = 1,
    parameter int TA_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW/8-1:0]  be,
    output logic             ack,
    output logic             cap,
    output logic             zero_rd,
    output ctl_state_t       st_d,
    output logic [AW-1:0]    f_addr_d,
    output logic [DW-1:0]    f_wdata_d,
    output logic [DW/8-1:0]  f_be_d,
    output logic [DW/8-1:0]  f_be_q
);

    localparam int LANES   = DW / 8;
    localparam int CNT_MAX = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
    localparam int CW      = $clog2(CNT_MAX + 2);
    localparam int TW      = $clog2(TA_CYC + 2);
    localparam logic [CW-1:0] RD_LAST = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WP_LAST = CW'(WP_CYC - 1);
    localparam logic [TW-1:0] TA_LOAD = TW'(TA_CYC);

    ctl_state_t          st_q;
    logic [CW-1:0]       cnt_q, cnt_d;
    logic [TW-1:0]       ta_q, ta_d;
    logic                ack_d;
    logic                accept;
    logic [AW-1:0]       f_addr_q;
    logic [DW-1:0]       f_wdata_q;
    logic                empty_mask;

    assign empty_mask = (be == '0);
    // A driving write waits for the turnaround window; reads and empty masks do not.
    assign accept = (st_q == ST_IDLE) && req && (!we || empty_mask || ta_q == '0);

    // Purpose: request fields seen by the pin stage on the next edge.
    assign f_addr_d  = accept ? addr  : f_addr_q;
    assign f_wdata_d = accept ? wdata : f_wdata_q;
    assign f_be_d    = accept ? be    : f_be_q;

    // Purpose: next phase, counter, ack and capture strobes.
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        ack_d   = 1'b0;
        cap     = 1'b0;
        zero_rd = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    if (empty_mask) begin
                        ack_d   = 1'b1;
                        zero_rd = !we;
                    end else if (we) begin
                        st_d = ST_WSETUP;
                    end else begin
                        st_d  = ST_READ;
                        cnt_d = RD_LAST;
                    end
                end
            end
            ST_READ: begin
                if (cnt_q == '0) begin
                    cap   = 1'b1;
                    ack_d = 1'b1;
                    st_d  = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            ST_WSETUP: begin
                st_d  = ST_WPULSE;
                cnt_d = WP_LAST;
            end
            ST_WPULSE: begin
                if (cnt_q == '0) begin
                    ack_d = 1'b1;
                    st_d  = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Purpose: turnaround window opens when a read ends and counts down.
    always_comb begin
        ta_d = ta_q;
        if (cap) begin
            ta_d = TA_LOAD;
        end else if (ta_q != '0) begin
            ta_d = ta_q - TW'(1);
        end
    end

    // Purpose: state, counters, ack and latched request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            ta_q      <= '0;
            ack       <= 1'b0;
            f_addr_q  <= '0;
            f_wdata_q <= '0;
            f_be_q    <= '0;
        end else begin
            st_q      <= st_d;
            cnt_q     <= cnt_d;
            ta_q      <= ta_d;
            ack       <= ack_d;
            f_addr_q  <= f_addr_d;
            f_wdata_q <= f_wdata_d;
            f_be_q    <= f_be_d;
        end
    end

    if (LANES < 1) begin : g_bad_width
        initial $display("sram_ctl_seq: DW must be at least 8");
    end

endmodule

// File: rtl/sram_ctl_pins.sv
// Pin stage: registers every RAM strobe, address and driver from the
// sequencer's next phase, so the pins change only on clock edges.
// Assumes: the address changes only on an accept, when chip select is high.
module sram_ctl_pins
    import sram_ctl_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_state_t       st_d,
    input  logic [AW-1:0]    f_addr_d,
    input  logic [DW-1:0]    f_wdata_d,
    input  logic [DW/8-1:0]  f_be_d,
    output logic [AW-1:0]    sram_addr,
    output logic             sram_cs_n,
    output logic             sram_oe_n,
    output logic             sram_we_n,
    output logic [DW/8-1:0]  sram_bsel_n,
    output logic [DW-1:0]    sram_dq_out,
    output logic             sram_dq_oe
);

    localparam int LANES = DW / 8;

    logic sel_d;
    assign sel_d = (st_d != ST_IDLE);

    // Purpose: shared strobes, address and data driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr   <= '0;
            sram_cs_n   <= 1'b1;
            sram_oe_n   <= 1'b1;
            sram_we_n   <= 1'b1;
            sram_dq_out <= '0;
            sram_dq_oe  <= 1'b0;
        end else begin
            sram_addr   <= f_addr_d;
            sram_cs_n   <= !sel_d;
            sram_oe_n   <= !(st_d == ST_READ);
            sram_we_n   <= !(st_d == ST_WPULSE);
            sram_dq_out <= f_wdata_d;
            sram_dq_oe  <= (st_d == ST_WPULSE);
        end
    end

    // Purpose: one active-low select per byte lane, framed by chip select.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sram_bsel_n[l] <= 1'b1;
            end else begin
                sram_bsel_n[l] <= !(sel_d && f_be_d[l]);
            end
        end
    end

endmodule

// File: rtl/sram_ctl_rdcap.sv
// Read capture: samples the data pins at the end of the read access,
// zeroes lanes outside the mask, and pulses rvalid.
// Assumes: cap and zero_rd are never high together.
module sram_ctl_rdcap #(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic             zero_rd,
    input  logic [DW/8-1:0]  mask,
    input  logic [DW-1:0]    dq_in,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);

    localparam int LANES = DW / 8;

    // Purpose: valid pulse for both a real and an empty-mask read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= cap || zero_rd;
        end
    end

    // Purpose: per-lane capture with masking.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[l*8 +: 8] <= '0;
            end else if (cap) begin
                rdata[l*8 +: 8] <= mask[l] ? dq_in[l*8 +: 8] : 8'h00;
            end else if (zero_rd) begin
                rdata[l*8 +: 8] <= 8'h00;
            end
        end
    end

endmodule

// File: rtl/sram_ctl.sv
// Top of the asynchronous static RAM controller: sequencer, pin stage and
// read capture. Assumes the data pins are resolved outside this block from
// sram_dq_out / sram_dq_oe, and sram_dq_in carries what the pins show.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW     = 18,
    parameter int DW     = 16,
    parameter int RD_CYC = 2,
    parameter int WP_CYC = 1,
    parameter int TA_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW/8-1:0]  be,
    output logic             ack,
    output logic             rvalid,
    output logic [DW-1:0]    rdata,
    output logic [AW-1:0]    sram_addr,
    output logic             sram_cs_n,
    output logic             sram_oe_n,
    output logic             sram_we_n,
    output logic [DW/8-1:0]  sram_bsel_n,
    output logic [DW-1:0]    sram_dq_out,
    output logic             sram_dq_oe,
    input  logic [DW-1:0]    sram_dq_in
);

    localparam int LANES = DW / 8;

    ctl_state_t          st_d;
    logic                cap, zero_rd;
    logic [AW-1:0]       f_addr_d;
    logic [DW-1:0]       f_wdata_d;
    logic [LANES-1:0]    f_be_d, f_be_q;

    sram_ctl_seq #(
        .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .be(be), .ack(ack), .cap(cap), .zero_rd(zero_rd),
        .st_d(st_d), .f_addr_d(f_addr_d), .f_wdata_d(f_wdata_d),
        .f_be_d(f_be_d), .f_be_q(f_be_q)
    );

    sram_ctl_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk(clk), .rst_n(rst_n), .st_d(st_d), .f_addr_d(f_addr_d),
        .f_wdata_d(f_wdata_d), .f_be_d(f_be_d), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_bsel_n(sram_bsel_n), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe)
    );

    sram_ctl_rdcap #(.DW(DW)) u_rdcap (
        .clk(clk), .rst_n(rst_n), .cap(cap), .zero_rd(zero_rd),
        .mask(f_be_q), .dq_in(sram_dq_in), .rdata(rdata), .rvalid(rvalid)
    );

endmodule

// File: rtl/sram_ctl_chk.sv
// Protocol checker bound to sram_ctl: strobe overlap, address hold,
// driver framing and read-to-write turnaround.
// Assumes: synchronous active-low reset on rst_n.
module sram_ctl_chk #(
    parameter int AW     = 18,
    parameter int DW     = 16,
    parameter int TA_CYC = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             rvalid,
    input logic [AW-1:0]    sram_addr,
    input logic             sram_cs_n,
    input logic             sram_oe_n,
    input logic             sram_we_n,
    input logic [DW/8-1:0]  sram_bsel_n,
    input logic             sram_dq_oe
);

    localparam int GW = $clog2(TA_CYC + 3);
    localparam logic [GW-1:0] GAP_SAT = GW'(TA_CYC + 2);

    logic [GW-1:0] gap_q;

    // Purpose: cycles since output enable was last low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GAP_SAT;
        end else if (!sram_oe_n) begin
            gap_q <= '0;
        end else if (gap_q != GAP_SAT) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    assert_drv_in_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (!sram_we_n && !sram_cs_n));

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    assert_no_rw_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n));

    assert_some_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_cs_n |-> (sram_bsel_n != '1));

    assert_rvalid_with_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> ack);

    assert_read_end_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> rvalid);

    assert_we_after_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> $past(!sram_cs_n));

    assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (gap_q >= GAP_SAT));

endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .DW(DW), .TA_CYC(TA_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .rvalid(rvalid),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_bsel_n(sram_bsel_n), .sram_dq_oe(sram_dq_oe)
);

// File: tb/tb_sram_ctl.sv
// Bench for sram_ctl: byte-lane RAM model with strobe rules, directed
// corner cases and a seeded random stream checked against a shadow memory.
module tb_sram_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 18, DW = 16;
    localparam int RD = 2, WP = 1, TA = 1;
    localparam int RD_ACC = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [1:0] be = '0;
    logic ack, rvalid;
    logic [DW-1:0] rdata;
    logic [AW-1:0] sram_addr;
    logic sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [1:0] sram_bsel_n;
    logic [DW-1:0] sram_dq_out, sram_dq_in;

    sram_ctl #(.AW(AW), .DW(DW), .RD_CYC(RD), .WP_CYC(WP), .TA_CYC(TA)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .be(be), .ack(ack), .rvalid(rvalid), .rdata(rdata),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_bsel_n(sram_bsel_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0, checks = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- RAM model (indexed by addr[7:0]) ----------------
    logic [15:0] mem [256];
    logic [15:0] shadow [256];
    int  rd_age = 0, we_low = 0, viol_addr = 0, viol_drv = 0, viol_conf = 0;
    bit  cs_seen = 0;
    logic [1:0] bsel_seen = 2'b11;
    logic [AW-1:0] cur_addr = '0;
    bit  prev_wr = 0, prev_rd = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [1:0] prev_bsel = 2'b11;
    logic [15:0] pend_data = '0;
    logic [1:0] pend_bsel = 2'b11;
    logic [7:0] pend_idx = '0;

    always @(negedge clk) begin
        bit wr_act, rd_act;
        wr_act = !sram_cs_n && !sram_we_n && (sram_bsel_n != 2'b11);
        rd_act = !sram_cs_n && !sram_oe_n && sram_we_n;
        if (rst_n) begin
            if (!sram_cs_n) begin
                cs_seen = 1;
                bsel_seen = sram_bsel_n;
                if (sram_addr != cur_addr) viol_addr++;
            end
            if (!sram_we_n) we_low++;
            if (sram_dq_oe && !sram_oe_n && !sram_cs_n) viol_conf++;
            if (wr_act) begin
                if (!sram_dq_oe) viol_drv++;
                if (prev_wr && sram_addr != prev_addr) viol_addr++;
                pend_data = sram_dq_out;
                pend_bsel = sram_bsel_n;
                pend_idx  = sram_addr[7:0];
            end else if (prev_wr) begin
                if (!pend_bsel[0]) mem[pend_idx][7:0]  = pend_data[7:0];
                if (!pend_bsel[1]) mem[pend_idx][15:8] = pend_data[15:8];
            end
            if (rd_act && prev_rd && sram_addr == prev_addr && sram_bsel_n == prev_bsel)
                rd_age++;
            else if (rd_act) rd_age = 1;
            else rd_age = 0;
        end
        prev_wr = wr_act; prev_rd = rd_act;
        prev_addr = sram_addr; prev_bsel = sram_bsel_n;
    end

    // Undriven lanes read 8'hC3; a lane not yet settled reads 8'h3C.
    always_comb begin
        for (int l = 0; l < 2; l++) begin
            if (!sram_cs_n && !sram_oe_n && sram_we_n && !sram_bsel_n[l])
                sram_dq_in[l*8 +: 8] = (rd_age >= RD_ACC) ? mem[sram_addr[7:0]][l*8 +: 8] : 8'h3C;
            else
                sram_dq_in[l*8 +: 8] = 8'hC3;
        end
    end

    function automatic logic [15:0] exp_read(input logic [AW-1:0] a, input logic [1:0] m);
        exp_read = {m[1] ? shadow[a[7:0]][15:8] : 8'h00, m[0] ? shadow[a[7:0]][7:0] : 8'h00};
    endfunction

    int rd_done = -100;

    // One request; returns at the negedge where ack is seen, with req dropped.
    task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] m, input string tag);
        int c0, exp_ack, n;
        c0 = cyc;
        cur_addr = a; cs_seen = 0; we_low = 0; bsel_seen = 2'b11;
        req = 1; we = w; addr = a; wdata = d; be = m;
        if (m == 2'b00) exp_ack = c0 + 1;
        else if (!w) exp_ack = c0 + 1 + RD;
        else exp_ack = ((c0 + 1 > rd_done + TA + 1) ? c0 + 1 : rd_done + TA + 1) + 1 + WP;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ack && n < 60);
        req = 0;
        chk(ack == 1'b1 && cyc == exp_ack, {tag, " R10 R7 ack timing"}, cyc - c0, exp_ack - c0);
        if (m == 2'b00) begin
            chk(!cs_seen, {tag, " R8 no strobe"}, cs_seen, 0);
            if (!w) chk(rvalid && rdata == 16'h0, {tag, " R8 empty read"}, {rvalid, rdata}, {1'b1, 16'h0});
        end else if (!w) begin
            chk(rvalid && rdata == exp_read(a, m), {tag, " R3 read data"}, {rvalid, rdata}, {1'b1, exp_read(a, m)});
            chk(bsel_seen == ~m, {tag, " R2 byte selects"}, bsel_seen, ~m);
            rd_done = cyc;
        end else begin
            chk(!rvalid && we_low == WP, {tag, " R4 write pulse"}, {rvalid, we_low[7:0]}, WP);
            if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
            if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
        end
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'(i * 257) ^ 16'h5A3C;
            shadow[i] = mem[i];
        end
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk({sram_cs_n, sram_oe_n, sram_we_n, sram_bsel_n, sram_dq_oe, ack, rvalid} == 8'b11111000,
            "R1 reset pins", {sram_cs_n, sram_oe_n, sram_we_n, sram_bsel_n, sram_dq_oe, ack, rvalid}, 8'b11111000);
        // R4 R3 full word write then read
        do_req(1, 18'h2A512, 16'hBEEF, 2'b11, "dir wr full");
        idle(3);
        do_req(0, 18'h2A512, 16'h0, 2'b11, "dir rd full");
        // R4 lower-lane write leaves upper lane
        idle(4);
        do_req(1, 18'h3FF07, 16'h1234, 2'b01, "dir wr low");
        do_req(0, 18'h3FF07, 16'h0, 2'b11, "dir rd after low");
        // R3 single-lane reads
        do_req(0, 18'h3FF07, 16'h0, 2'b10, "dir rd upper");
        do_req(0, 18'h3FF07, 16'h0, 2'b01, "dir rd lower");
        // R7 write right after read pays the turnaround
        do_req(1, 18'h00011, 16'hA55A, 2'b10, "dir wr after rd");
        // R10 write after write
        do_req(1, 18'h00012, 16'h0F0F, 2'b11, "dir wr after wr");
        // R8 empty masks
        do_req(1, 18'h00012, 16'hFFFF, 2'b00, "dir wr empty");
        do_req(0, 18'h00012, 16'h0, 2'b00, "dir rd empty");
        do_req(0, 18'h00012, 16'h0, 2'b11, "dir rd after empty wr");
        // Random stream: mixed gaps 0..2 exercise the turnaround window
        for (int i = 0; i < 400; i++) begin
            int g;
            logic [AW-1:0] ra;
            g = (($urandom % 3) == 0) ? int'($urandom % 3) : 0;
            idle(g);
            ra = {$urandom % 4 == 0 ? 10'(i) : 10'h155, 8'($urandom % 24)};
            do_req($urandom % 2 == 1, ra, 16'($urandom), 2'($urandom), "rand");
        end
        idle(4);
        // R5 R6 R9 pin rules observed by the RAM model
        chk(viol_addr == 0, "R5 address hold", viol_addr, 0);
        chk(viol_drv == 0, "R6 driver during strobe", viol_drv, 0);
        chk(viol_conf == 0, "R9 read/write overlap", viol_conf, 0);
        finish_run();
    end

endmodule